// File: doc/BRIEF.md
# Rotate, Shift and Bit Manipulation Unit

This combinational unit performs the byte-wide rotate, shift, bit-test, bit-clear and bit-set group on a single 8-bit operand. It takes the operand, the current flag byte and a decoded operation, and in the same cycle it returns the result byte, the updated flag byte and a write enable. The write enable tells the surrounding datapath whether the result must be stored back.

The operation is given by three fields taken from the prefixed opcode. A 2-bit class field selects shift/rotate, test, clear or set. A 3-bit shift selector picks one of eight shift variants. A 3-bit index names the bit that the test, clear and set classes act on. Operand fetch, indexed addressing and the two undefined flag bits are handled outside this unit.

Top module: `rsb_unit`

## Requirements
- R1: Class 2'b00 with shift select 3'd0 rotates left: bit 7 moves to bit 0 and also to carry (flag bit 0).
- R2: Class 2'b00 with shift select 3'd1 rotates right: bit 0 moves to bit 7 and also to carry.
- R3: Shift selects 3'd2 (left) and 3'd3 (right) rotate through carry: the incoming carry fills the empty bit and the bit shifted out becomes the new carry.
- R4: Shift select 3'd4 shifts left and shift select 3'd7 shifts right, each filling with 0. The bit shifted out goes to carry.
- R5: Shift select 3'd5 shifts right and keeps bit 7 unchanged. Bit 0 goes to carry.
- R6: Shift select 3'd6 shifts left and fills bit 0 with 1. Bit 7 goes to carry.
- R7: For class 2'b00 the flag byte is built from the result as follows. Sign (bit 7) is result bit 7. Zero (bit 6) is set when the result is 0. Parity (bit 2) is set for even parity. Half-carry (bit 4), subtract (bit 1) and bits 5 and 3 are 0. The write enable is 1.
- R8: Class 2'b01 tests bit n of the operand through the masked value operand & (1<<n). Sign is masked bit 7. Zero and parity are both set when the masked value is 0. Half-carry is 1. Subtract and bits 5 and 3 are 0. Carry is passed through from the incoming flags.
- R9: Class 2'b01 never writes: the write enable is 0 and the result output equals the operand.
- R10: Class 2'b10 clears bit n and leaves every other operand bit unchanged. The flag byte is passed through unchanged and the write enable is 1.
- R11: Class 2'b11 sets bit n and leaves every other operand bit unchanged. The flag byte is passed through unchanged and the write enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 8 | Incoming flag byte |
| cls_i | input | 2 | Operation class: 00 shift/rotate, 01 test, 10 clear, 11 set |
| shsel_i | input | 3 | Shift variant select |
| bidx_i | input | 3 | Bit index for the test, clear and set classes |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | Updated flag byte |
| wr_en_o | output | 1 | Result must be written back |

## Verification
Directed vectors hit the edge bits and the carry: an operand with only bit 7 set shows whether rotate-left and plain shift-left differ in what enters bit 0, an operand with only bit 0 set does the same for the right shifts, and 0x00 with a one-fill or carry-in shows whether the zero flag follows the inserted bit. Testing bit 7 of 0x80 and bit 0 of 0xFE separates the sign flag from the zero flag, and from parity. Random operands with random incoming flags then run through every class, shift variant and index. Each check looks at the result, the flag byte and the write enable, so a carry or flag that is passed through wrongly for the clear and set classes is also caught.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  // flag byte bit positions
  localparam int FLG_C = 0;
  localparam int FLG_N = 1;
  localparam int FLG_P = 2;
  localparam int FLG_H = 4;
  localparam int FLG_Z = 6;
  localparam int FLG_S = 7;

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_TEST  = 2'b01,
    CLS_CLEAR = 2'b10,
    CLS_FORCE = 2'b11
  } cls_e;

  typedef enum logic [2:0] {
    SH_ROTL     = 3'd0,
    SH_ROTR     = 3'd1,
    SH_ROTL_CY  = 3'd2,
    SH_ROTR_CY  = 3'd3,
    SH_LEFT_0   = 3'd4,
    SH_RIGHT_AR = 3'd5,
    SH_LEFT_1   = 3'd6,
    SH_RIGHT_0  = 3'd7
  } shsel_e;
endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter
  import rsb_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] val_i,
  input  logic         cin_i,
  input  logic [2:0]   sel_i,
  output logic [W-1:0] val_o,
  output logic         cout_o
);
  localparam int MSB = W - 1;

  always_comb begin
    val_o  = val_i;
    cout_o = 1'b0;
    unique case (shsel_e'(sel_i))
      SH_ROTL: begin
        val_o  = {val_i[MSB-1:0], val_i[MSB]};
        cout_o = val_i[MSB];
      end
      SH_ROTR: begin
        val_o  = {val_i[0], val_i[MSB:1]};
        cout_o = val_i[0];
      end
      SH_ROTL_CY: begin
        val_o  = {val_i[MSB-1:0], cin_i};
        cout_o = val_i[MSB];
      end
      SH_ROTR_CY: begin
        val_o  = {cin_i, val_i[MSB:1]};
        cout_o = val_i[0];
      end
      SH_LEFT_0: begin
        val_o  = {val_i[MSB-1:0], 1'b0};
        cout_o = val_i[MSB];
      end
      SH_RIGHT_AR: begin
        val_o  = {val_i[MSB], val_i[MSB:1]};
        cout_o = val_i[0];
      end
      SH_LEFT_1: begin
        val_o  = {val_i[MSB-1:0], 1'b1};
        cout_o = val_i[MSB];
      end
      default: begin
        val_o  = {1'b0, val_i[MSB:1]};
        cout_o = val_i[0];
      end
    endcase
  end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
  import rsb_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic [W-1:0]  val_i,
  input  logic [IW-1:0] idx_i,
  output logic [W-1:0]  masked_o,
  output logic [W-1:0]  cleared_o,
  output logic [W-1:0]  forced_o
);
  logic [W-1:0] onehot;

  for (genvar g = 0; g < W; g++) begin : g_dec
    assign onehot[g] = (idx_i == IW'(g));
  end

  assign masked_o  = val_i & onehot;
  assign cleared_o = val_i & ~onehot;
  assign forced_o  = val_i | onehot;
endmodule

// File: rtl/rsb_flags.sv
module rsb_flags
  import rsb_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [1:0]   cls_i,
  input  logic [7:0]   flags_i,
  input  logic [W-1:0] shval_i,
  input  logic         shcy_i,
  input  logic [W-1:0] masked_i,
  output logic [7:0]   flags_o
);
  function automatic logic [7:0] szp(input logic [W-1:0] v);
    logic [7:0] f;
    f        = '0;
    f[FLG_S] = v[W-1];
    f[FLG_Z] = (v == '0);
    f[FLG_P] = ~(^v);
    return f;
  endfunction

  always_comb begin
    unique case (cls_e'(cls_i))
      CLS_SHIFT: begin
        flags_o        = szp(shval_i);
        flags_o[FLG_C] = shcy_i;
      end
      CLS_TEST: begin
        flags_o        = szp(masked_i);
        flags_o[FLG_H] = 1'b1;
        flags_o[FLG_C] = flags_i[FLG_C];
      end
      default: flags_o = flags_i;
    endcase
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
(
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  input  logic [1:0] cls_i,
  input  logic [2:0] shsel_i,
  input  logic [2:0] bidx_i,
  output logic [7:0] result_o,
  output logic [7:0] flags_o,
  output logic       wr_en_o
);
  logic [DATA_W-1:0] sh_val;
  logic              sh_cy;
  logic [DATA_W-1:0] bt_masked;
  logic [DATA_W-1:0] bt_cleared;
  logic [DATA_W-1:0] bt_forced;

  rsb_shifter #(.W(DATA_W)) u_shift (
    .val_i (opnd_i),
    .cin_i (flags_i[FLG_C]),
    .sel_i (shsel_i),
    .val_o (sh_val),
    .cout_o(sh_cy)
  );

  rsb_bitop #(.W(DATA_W), .IW(IDX_W)) u_bit (
    .val_i    (opnd_i),
    .idx_i    (bidx_i),
    .masked_o (bt_masked),
    .cleared_o(bt_cleared),
    .forced_o (bt_forced)
  );

  rsb_flags #(.W(DATA_W)) u_flg (
    .cls_i   (cls_i),
    .flags_i (flags_i),
    .shval_i (sh_val),
    .shcy_i  (sh_cy),
    .masked_i(bt_masked),
    .flags_o (flags_o)
  );

  always_comb begin
    unique case (cls_e'(cls_i))
      CLS_SHIFT: result_o = sh_val;
      CLS_TEST:  result_o = opnd_i;
      CLS_CLEAR: result_o = bt_cleared;
      default:   result_o = bt_forced;
    endcase
  end

  assign wr_en_o = (cls_i != CLS_TEST);
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk (
  input logic [7:0] opnd_i,
  input logic [7:0] flags_i,
  input logic [1:0] cls_i,
  input logic [2:0] shsel_i,
  input logic [2:0] bidx_i,
  input logic [7:0] result_o,
  input logic [7:0] flags_o,
  input logic       wr_en_o
);
  logic [7:0] sel_bit;
  assign sel_bit = 8'(1) << bidx_i;

  always_comb begin
    if (!$isunknown({opnd_i, flags_i, cls_i, shsel_i, bidx_i})) begin
      if (cls_i == 2'b01) begin
        AST_TEST_NO_WRITE: assert (!wr_en_o && result_o == opnd_i); // R9
        AST_TEST_KEEP_CY: assert (flags_o[0] == flags_i[0] && flags_o[4]); // R8
      end
      if (cls_i[1]) begin
        AST_BITOP_FLAGS_HELD: assert (flags_o == flags_i); // R10
        AST_BITOP_ONE_BIT: assert (((result_o ^ opnd_i) & ~sel_bit) == 8'h00); // R11
      end
      if (cls_i == 2'b00) begin
        AST_SHIFT_PARITY: assert (flags_o[2] == ~(^result_o)); // R7
        AST_SHIFT_H_N_CLEAR: assert (flags_o[4] == 1'b0 && flags_o[1] == 1'b0); // R7
        AST_SHIFT_COUNT: assert ($countones(result_o) <= $countones(opnd_i) + 1); // R6
      end
    end
  end
endmodule

bind rsb_unit rsb_unit_chk i_chk (
  .opnd_i  (opnd_i),
  .flags_i (flags_i),
  .cls_i   (cls_i),
  .shsel_i (shsel_i),
  .bidx_i  (bidx_i),
  .result_o(result_o),
  .flags_o (flags_o),
  .wr_en_o (wr_en_o)
);

// File: tb/test_rsb_unit.sv
`timescale 1ns/1ps
module test_rsb_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] opnd, flg;
  logic [1:0] cls;
  logic [2:0] shsel, bidx;
  logic [7:0] res, fout;
  logic       we;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  rsb_unit i_rsb_unit (
    .opnd_i(opnd), .flags_i(flg), .cls_i(cls), .shsel_i(shsel),
    .bidx_i(bidx), .result_o(res), .flags_o(fout), .wr_en_o(we)
  );

  // reference model written from the requirements
  function automatic logic [17:0] ref_model(input logic [7:0] a, input logic [7:0] f,
                                            input logic [1:0] c, input logic [2:0] s,
                                            input logic [2:0] n);
    logic [7:0] r, fo, m;
    logic [8:0] wide;
    logic w;
    int ones;
    r = a; fo = f; w = 1'b1;
    case (c)
      2'b00: begin
        case (s)
          3'd0: wide = {a[7], a[6:0], a[7]};
          3'd1: wide = {a[0], a[0], a[7:1]};
          3'd2: wide = {a, f[0]};
          3'd3: wide = {a[0], f[0], a[7:1]};
          3'd4: wide = {a, 1'b0};
          3'd5: wide = {a[0], a[7], a[7:1]};
          3'd6: wide = {a, 1'b1};
          default: wide = {a[0], 1'b0, a[7:1]};
        endcase
        r = wide[7:0];
        ones = 0;
        for (int i = 0; i < 8; i++) ones += r[i];
        fo = {r[7], (r == 8'h00), 1'b0, 1'b0, 1'b0, (ones % 2 == 0), 1'b0, wide[8]};
      end
      2'b01: begin
        m = a & (8'h01 << n);
        fo = {m[7], (m == 8'h00), 1'b0, 1'b1, 1'b0, (m == 8'h00), 1'b0, f[0]};
        w = 1'b0;
      end
      2'b10: r = a & ~(8'h01 << n);
      default: r = a | (8'h01 << n);
    endcase
    return {w, fo, r[7:0], 1'b0} >> 1;
  endfunction

  function automatic string req_of(input logic [1:0] c, input logic [2:0] s);
    if (c == 2'b01) return "R8/R9";
    if (c == 2'b10) return "R10";
    if (c == 2'b11) return "R11";
    case (s)
      3'd0: return "R1/R7";
      3'd1: return "R2/R7";
      3'd2, 3'd3: return "R3/R7";
      3'd4, 3'd7: return "R4/R7";
      3'd5: return "R5/R7";
      default: return "R6/R7";
    endcase
  endfunction

  task automatic apply_check(input logic [7:0] a, input logic [7:0] f, input logic [1:0] c,
                             input logic [2:0] s, input logic [2:0] n);
    logic [17:0] exp;
    @(negedge clk);
    opnd = a; flg = f; cls = c; shsel = s; bidx = n;
    #1;
    exp = ref_model(a, f, c, s, n);
    n_chk++;
    if ({we, fout, res} !== exp[16:0]) begin
      n_err++;
      $display("FAIL %s: op=%h fl=%h cls=%0d sh=%0d idx=%0d got we=%b f=%h r=%h exp we=%b f=%h r=%h",
               req_of(c, s), a, f, c, s, n, we, fout, res, exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: expired, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    // directed corner cases
    apply_check(8'h80, 8'h00, 2'b00, 3'd0, 3'd0); // R1: 0x01, C=1
    apply_check(8'h01, 8'h00, 2'b00, 3'd1, 3'd0); // R2: 0x80, C=1
    apply_check(8'h00, 8'h01, 2'b00, 3'd2, 3'd0); // R3: carry in enters bit 0
    apply_check(8'h00, 8'h01, 2'b00, 3'd3, 3'd0); // R3: carry in enters bit 7
    apply_check(8'h80, 8'hFF, 2'b00, 3'd4, 3'd0); // R4: zero result, C=1
    apply_check(8'h01, 8'hFF, 2'b00, 3'd7, 3'd0); // R4
    apply_check(8'h81, 8'h00, 2'b00, 3'd5, 3'd0); // R5: 0xC0, C=1
    apply_check(8'h00, 8'h00, 2'b00, 3'd6, 3'd0); // R6: 0x01, not zero
    apply_check(8'h80, 8'h00, 2'b00, 3'd6, 3'd0); // R6
    apply_check(8'h80, 8'h01, 2'b01, 3'd0, 3'd7); // R8: S=1
    apply_check(8'hFE, 8'h00, 2'b01, 3'd0, 3'd0); // R8: Z=P=1; R9
    apply_check(8'hFF, 8'hD7, 2'b10, 3'd0, 3'd3); // R10
    apply_check(8'h00, 8'h28, 2'b11, 3'd0, 3'd7); // R11
    // random sweep, R1..R11
    for (int k = 0; k < 2000; k++) begin
      apply_check(8'($urandom), 8'($urandom), 2'($urandom), 3'($urandom), 3'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule